// File: doc/BRIEF.md
# Character Position to Display RAM Address Mapper

This block turns a visible character cell, given as a line select and a column index, into the display RAM address whose byte belongs in that cell. It supports a single long line that uses 80 bytes of RAM, and a two-line layout in which each line has its own 40-byte band. The two bands are not adjacent: line one starts at 0x00 and line two starts at 0x40.

A horizontal scroll offset rotates the visible window around each line's band. A left shift moves later bytes into view. A right shift moves earlier bytes into view and wraps past the start of the band to its last byte. In two-line mode both lines scroll together by the same amount. The offset can be cleared with a single pulse. It is also cleared automatically whenever the line-count mode changes.

The address is registered, so it appears one cycle after the request. The number of visible columns per line is set by a parameter.

Top module: `charpos_addr_map`

## Requirements
- R1: While rst_ni is low and after its release, before any other input acts, offset_o is 0 and addr_o is 0x00.
- R2: In one-line mode (two_line_i=0) with offset 0, a request for column c gives addr_o = c one cycle later.
- R3: In two-line mode (two_line_i=1) with offset 0, line_i=0 gives addr_o = c and line_i=1 gives addr_o = 0x40 + c.
- R4: The shift command is encoded as follows. shift_vld_i=1 with shift_right_i=0 is a left shift, which raises the offset by one. shift_vld_i=1 with shift_right_i=1 is a right shift, which lowers it by one. With a nonzero offset f, addr_o = base + ((c + f) mod L), where L is 80 in one-line mode and 40 in two-line mode.
- R5: A right shift from offset 0 sets the offset to L-1. After it, column 0 maps to 0x4F in one-line mode, and to 0x27 (line 0) or 0x67 (line 1) in two-line mode.
- R6: A left shift from offset L-1 wraps the offset to 0. Addresses never leave the active band: 0x00–0x4F in one-line mode, and 0x00–0x27 or 0x40–0x67 in two-line mode.
- R7: shift_clr_i=1 sets the offset to 0 at the next edge, even if a shift command is present in the same cycle.
- R8: A change of two_line_i from its value in the previous cycle sets the offset to 0 at that edge. Any shift command in that cycle is ignored.
- R9: In one-line mode, line_i is ignored and the request is mapped as line 0.
- R10: addr_o is computed from the inputs and the offset as they stand before each edge. A shift issued in the same cycle as a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_line_i | input | 1 | 1 selects the two-line layout, 0 selects the one-line layout |
| shift_vld_i | input | 1 | Shift command strobe |
| shift_right_i | input | 1 | Shift direction: 1 is right, 0 is left |
| shift_clr_i | input | 1 | Clears the shift offset |
| line_i | input | 1 | Requested line (0 or 1) |
| col_i | input | $clog2(VIS_COLS) | Requested column, counted from 0 |
| addr_o | output | 7 | Registered display RAM address |
| offset_o | output | 7 | Current shift offset |

## Verification
The bench targets the wrap points of the offset:

- A right shift from zero. A design that wraps to the wrong band, or to the flat 80-byte space, shows 0x4F in place of 0x27 or 0x67.
- A left shift past L-1. A design that wraps late lets the offset reach 40 in two-line mode.
- Column plus offset crossing the band end. Here line two would spill into 0x68 and beyond.

It also issues a clear and a shift in the same cycle, and toggles the mode while the offset is nonzero, so a wrong priority leaves a stale offset. Finally, it pairs shifts with requests in the same cycle, where a design that forwards the new offset shows the address one step early.

// File: rtl/charpos_map_pkg.sv
package charpos_map_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned OFF_W      = 7;
  localparam int unsigned LEN_ONE    = 80;
  localparam int unsigned LEN_TWO    = 40;
  localparam logic [ADDR_W-1:0] LINE2_BASE = 7'h40;

  typedef enum logic [1:0] {SH_HOLD, SH_LEFT, SH_RIGHT, SH_ZERO} shift_op_e;
endpackage

// File: rtl/charpos_shift_ctr.sv
module charpos_shift_ctr
  import charpos_map_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             two_line_i,
  input  logic             shift_vld_i,
  input  logic             shift_right_i,
  input  logic             shift_clr_i,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [OFF_W-1:0] LAST_ONE = OFF_W'(LEN_ONE - 1);
  localparam logic [OFF_W-1:0] LAST_TWO = OFF_W'(LEN_TWO - 1);

  logic             mode_q;
  logic [OFF_W-1:0] off_q, off_d, last;
  shift_op_e        op;

  assign last = mode_q ? LAST_TWO : LAST_ONE;

  always_comb begin
    if (shift_clr_i || (two_line_i != mode_q)) op = SH_ZERO;
    else if (shift_vld_i)                      op = shift_right_i ? SH_RIGHT : SH_LEFT;
    else                                       op = SH_HOLD;
  end

  always_comb begin
    unique case (op)
      SH_ZERO:  off_d = '0;
      SH_LEFT:  off_d = (off_q == last) ? '0 : off_q + 1'b1;
      SH_RIGHT: off_d = (off_q == '0) ? last : off_q - 1'b1;
      default:  off_d = off_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      off_q  <= off_d;
      mode_q <= two_line_i;
    end
  end

  assign off_o = off_q;

  p_off_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= (mode_q ? LAST_TWO : LAST_ONE));
  p_clr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_clr_i |=> off_q == '0);
  p_mode_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (two_line_i != mode_q) |=> off_q == '0);
  p_right_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_vld_i && shift_right_i && !shift_clr_i && two_line_i == mode_q && off_q == '0)
    |=> off_q == (two_line_i ? LAST_TWO : LAST_ONE));
endmodule

// File: rtl/charpos_addr_calc.sv
module charpos_addr_calc
  import charpos_map_pkg::*;
#(
  parameter int unsigned COL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              two_line_i,
  input  logic              line_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SW = OFF_W + 1;

  logic [SW-1:0]     len, off_eff, sum, pos;
  logic [ADDR_W-1:0] base, addr_q;

  assign len     = two_line_i ? SW'(LEN_TWO) : SW'(LEN_ONE);
  // offset may briefly exceed the band on the cycle the mode flips
  assign off_eff = ({1'b0, off_i} >= len) ? {1'b0, off_i} - len : {1'b0, off_i};
  assign sum     = SW'(col_i) + off_eff;
  assign pos     = (sum >= len) ? sum - len : sum;
  assign base    = (two_line_i && line_i) ? LINE2_BASE : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= base + pos[ADDR_W-1:0];
  end

  assign addr_o = addr_q;

  p_one_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !two_line_i |=> addr_q < ADDR_W'(LEN_ONE));
  p_two_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    two_line_i |=> (addr_q < ADDR_W'(LEN_TWO)) ||
                   (addr_q >= LINE2_BASE && addr_q < LINE2_BASE + ADDR_W'(LEN_TWO)));
  p_line2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (two_line_i && line_i) |=> addr_q[ADDR_W-1]);
endmodule

// File: rtl/charpos_addr_map.sv
module charpos_addr_map
  import charpos_map_pkg::*;
#(
  parameter int unsigned VIS_COLS = 8,
  localparam int unsigned COL_W   = $clog2(VIS_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              two_line_i,
  input  logic              shift_vld_i,
  input  logic              shift_right_i,
  input  logic              shift_clr_i,
  input  logic              line_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFF_W-1:0]  offset_o
);
  logic [OFF_W-1:0] off;

  generate
    if (VIS_COLS < 2 || VIS_COLS > LEN_TWO) begin : g_bad_cols
      initial $error("VIS_COLS must lie in 2..40");
    end
  endgenerate

  charpos_shift_ctr u_shift (
    .clk_i, .rst_ni, .two_line_i, .shift_vld_i, .shift_right_i, .shift_clr_i,
    .off_o(off)
  );

  charpos_addr_calc #(.COL_W(COL_W)) u_calc (
    .clk_i, .rst_ni, .two_line_i, .line_i, .col_i,
    .off_i(off), .addr_o
  );

  assign offset_o = off;
endmodule

// File: tb/sim_charpos_addr_map.sv
module sim_charpos_addr_map;
  localparam int VIS_COLS = 8;
  localparam int COL_W = $clog2(VIS_COLS);

  logic clk = 0, rst_ni = 0;
  logic two_line = 0, sh_vld = 0, sh_right = 0, sh_clr = 0, line = 0;
  logic [COL_W-1:0] col = '0;
  logic [6:0] addr, offs;

  int n_chk = 0, n_fail = 0;
  int m_off = 0, m_mode = 0;

  always #2.5 clk = ~clk;

  charpos_addr_map #(.VIS_COLS(VIS_COLS)) u0 (
    .clk_i(clk), .rst_ni, .two_line_i(two_line), .shift_vld_i(sh_vld),
    .shift_right_i(sh_right), .shift_clr_i(sh_clr), .line_i(line),
    .col_i(col), .addr_o(addr), .offset_o(offs)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare 1 ns later
  task automatic step(string tag, bit tl, bit v, bit r, bit c, bit ln, int cl);
    int len, e, exp_addr;
    @(negedge clk);
    two_line = tl; sh_vld = v; sh_right = r; sh_clr = c; line = ln; col = COL_W'(cl);
    @(posedge clk);
    len = tl ? 40 : 80;
    e = ((cl + (m_off % len)) % len) + ((tl && ln) ? 'h40 : 0);
    exp_addr = e;
    if (c || (int'(tl) != m_mode)) m_off = 0;
    else if (v) m_off = r ? (m_off + len - 1) % len : (m_off + 1) % len;
    m_mode = tl;
    #1;
    chk(tag, addr, exp_addr);
    chk(tag, offs, m_off);
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #12;
    chk("R1 addr in reset", addr, 0);
    chk("R1 offset in reset", offs, 0);
    rst_ni = 1;
    #1;
    chk("R1 addr after release", addr, 0);
    // R2 one-line, no shift
    for (int i = 0; i < VIS_COLS; i++) step("R2", 0, 0, 0, 0, 0, i);
    // R9 line select ignored in one-line mode
    step("R9", 0, 0, 0, 0, 1, 3);
    step("R9", 0, 0, 0, 0, 1, 7);
    // R5 right wrap in one-line: col 0 -> 0x4F
    step("R5 shift", 0, 1, 1, 0, 0, 0);
    step("R5 one-line 4F", 0, 0, 0, 0, 0, 0);
    step("R4 one-line shifted", 0, 0, 0, 0, 0, 5);
    // R7 clear beats shift
    step("R7", 0, 1, 0, 1, 0, 2);
    step("R7 after", 0, 0, 0, 0, 0, 2);
    // R3 two-line (mode change clears, R8)
    step("R8 mode flip", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < VIS_COLS; i++) begin
      step("R3 line0", 1, 0, 0, 0, 0, i);
      step("R3 line1", 1, 0, 0, 0, 1, i);
    end
    // R5 two-line right wrap: 0x27 and 0x67
    step("R5 shift", 1, 1, 1, 0, 0, 0);
    step("R5 two-line 27", 1, 0, 0, 0, 0, 0);
    step("R5 two-line 67", 1, 0, 0, 0, 1, 0);
    step("R6 band end", 1, 0, 0, 0, 1, 7);
    // R6 left wrap from 39 to 0
    step("R6 wrap", 1, 1, 0, 0, 1, 1);
    step("R6 after wrap", 1, 0, 0, 0, 1, 1);
    // R10 shift with request in same cycle
    step("R10 same-cycle", 1, 1, 0, 0, 0, 4);
    step("R10 next", 1, 0, 0, 0, 0, 4);
    // R8 mode change with nonzero offset and simultaneous shift
    for (int i = 0; i < 5; i++) step("R4 left", 1, 1, 0, 0, 1, i);
    step("R8 flip+shift", 0, 1, 0, 0, 0, 1);
    step("R8 after", 0, 0, 0, 0, 0, 1);
    // R6 one-line left wrap from 79
    step("R6 to 79", 0, 1, 1, 0, 0, 0);
    step("R6 wrap80", 0, 1, 0, 0, 0, 6);
    step("R6 after80", 0, 0, 0, 0, 0, 6);
    // R4 random mix
    for (int i = 0; i < 400; i++)
      step("R4 random", ($urandom % 16) == 0 ? ~two_line : two_line,
           $urandom % 2, $urandom % 2, ($urandom % 20) == 0,
           $urandom % 2, $urandom % VIS_COLS);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule